// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. It derives the high and low phase durations from a 12-bit clock-control value, counted in cycles of the peripheral clock. In standard mode the two phases are equal. In fast mode the low phase is twice the high phase, and an alternate duty setting gives a 16:9 low-to-high ratio. Control values that are too small for the selected mode are raised to that mode's minimum.

The block drives `scl_out`, where 1 releases the line and 0 pulls it low. It reads the real line level back on `scl_in`. Counting of the high phase starts only once the line is seen high, so a slow rise or a slave holding the clock low stretches the period and does not shorten it. Two one-cycle strobes mark the phase boundaries for a byte sequencer. `scl_fall_stb` marks the first cycle of each low phase, where SDA may change. `scl_rise_stb` marks the first counted high cycle, where SDA may be sampled.

Mode, duty and control value are captured only as a new low phase begins, so a change never cuts a phase short. With a peripheral clock of 8 MHz, standard mode and a value of 0x28, the clock runs at 100 kHz.

Top module: `scl_clk_gen`

## Requirements
- R1: With `fast_mode`=0, the low phase lasts C cycles and the high phase lasts C cycles, where C is the clamped control value. For C = 0x28 the period is 80 cycles.
- R2: With `fast_mode`=1 and `duty_alt`=0, the high phase lasts C cycles and the low phase lasts 2·C cycles.
- R3: With `fast_mode`=1 and `duty_alt`=1, the high phase lasts 9·C cycles and the low phase lasts 16·C cycles.
- R4: With `fast_mode`=0, or with `fast_mode`=1 and `duty_alt`=0, a control value below 4 is treated as 4.
- R5: With `fast_mode`=1 and `duty_alt`=1, a control value of 0 is treated as 1.
- R6: After the low phase ends, `scl_out` stays at 1. High-phase counting and `scl_rise_stb` wait until `scl_in` reads 1. The counted high phase then has its full length.
- R7: Changes to `fast_mode`, `duty_alt` or `ccr` made during a phase leave that phase unchanged. They take effect from the next low phase.
- R8: `scl_fall_stb` is 1 only in the first cycle of each low phase. `scl_rise_stb` is 1 only in the first counted high cycle, and only with `scl_in` at 1. The two strobes are never 1 together.
- R9: While `enable`=0, `scl_out`=1 and both strobes are 0. After `enable` rises, the first low phase begins on the next clock edge.
- R10: After reset, `scl_out`=1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator; 0 releases the line and clears state |
| fast_mode | input | 1 | 0 standard mode, 1 fast mode |
| duty_alt | input | 1 | In fast mode, 1 selects the 16:9 low-to-high ratio |
| ccr | input | 12 | Clock-control value in peripheral clock cycles |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_out | output | 1 | SCL drive: 1 release, 0 pull low |
| scl_fall_stb | output | 1 | Pulse in the first cycle of a low phase |
| scl_rise_stb | output | 1 | Pulse in the first counted high cycle |

## Verification
The bench measures low and high phase lengths under several settings: standard mode, fast mode with each duty setting, the 0x28 value, and values below each mode's minimum. Together these separate the three ratios from one another and show which clamp floor each mode uses. One test holds the line low after the low phase to show that high counting waits for the line to read high. Another changes the control value in mid high phase to show that the current phase keeps its old length and the next low phase takes the new one. Further tests cover disable, enable start-up and the exact cycles of the strobes.

// File: rtl/scl_clk_pkg.sv
// Package: shared types and sizing for the SCL clock generator.
// Assumes the control value is unsigned and that phase lengths stay below 2**CNT_W.
package scl_clk_pkg;
    localparam int CCR_W = 12;
    // The largest multiplier is 16, so four extra bits hold any phase length.
    localparam int CNT_W = CCR_W + 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;
endpackage

// File: rtl/scl_len_calc.sv
// Module: turns mode, duty and control value into high and low phase lengths.
// Purely combinational. The caller captures the result only at the start of a low phase.
module scl_len_calc
    import scl_clk_pkg::*;
(
    input  logic             fast_mode,
    input  logic             duty_alt,
    input  logic [CCR_W-1:0] ccr,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);
    logic [CCR_W-1:0] min_val;
    logic [CCR_W-1:0] c_eff;
    logic [CNT_W-1:0] c_w;

    // Clamp the control value to the minimum of the selected mode.
    always_comb begin
        min_val = (fast_mode && duty_alt) ? CCR_W'(1) : CCR_W'(4);
        c_eff   = (ccr < min_val) ? min_val : ccr;
        c_w     = CNT_W'(c_eff);
    end

    // Scale the clamped value by the mode's phase multipliers.
    always_comb begin
        if (!fast_mode) begin
            hi_len = c_w;
            lo_len = c_w;
        end else if (!duty_alt) begin
            hi_len = c_w;
            lo_len = c_w << 1;
        end else begin
            hi_len = (c_w << 3) + c_w;
            lo_len = c_w << 4;
        end
    end
endmodule

// File: rtl/scl_phase_ctrl.sv
// Module: phase sequencer and counter for SCL.
// It captures the phase lengths at each low-phase start. The low phase is counted
// at once. The high phase waits until the line reads high, and the cycle in which
// it is first seen high counts as high cycle 1. It assumes hi_len >= 2, which the
// clamps guarantee.
module scl_phase_ctrl
    import scl_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output phase_e           phase,
    output logic             first_low
);
    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;

    // Advance the phase state, count cycles and capture the lengths at each low start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (!enable) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PH_IDLE: begin
                    state <= PH_LOW;
                    cnt   <= CNT_W'(1);
                    hi_q  <= hi_len;
                    lo_q  <= lo_len;
                end
                PH_LOW: begin
                    if (cnt >= lo_q) begin
                        state <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        state <= PH_HIGH;
                        cnt   <= CNT_W'(2);
                    end
                end
                default: begin
                    if (cnt >= hi_q) begin
                        state <= PH_LOW;
                        cnt   <= CNT_W'(1);
                        hi_q  <= hi_len;
                        lo_q  <= lo_len;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Expose the phase and flag the first cycle of a low phase.
    always_comb begin
        phase     = state;
        first_low = (state == PH_LOW) && (cnt == CNT_W'(1));
    end
endmodule

// File: rtl/scl_clk_gen.sv
// Module: top of the I2C master SCL clock generator.
// It joins the length calculator and the phase sequencer and gates every output
// with enable, so a disabled block releases the line and issues no strobes.
module scl_clk_gen
    import scl_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_mode,
    input  logic             duty_alt,
    input  logic [CCR_W-1:0] ccr,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             scl_fall_stb,
    output logic             scl_rise_stb
);
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    phase_e           phase;
    logic             first_low;

    scl_len_calc u_len (
        .fast_mode (fast_mode),
        .duty_alt  (duty_alt),
        .ccr       (ccr),
        .hi_len    (hi_len),
        .lo_len    (lo_len)
    );

    scl_phase_ctrl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_in    (scl_in),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .phase     (phase),
        .first_low (first_low)
    );

    // Drive the line and the phase-boundary strobes.
    always_comb begin
        scl_out      = !(enable && (phase == PH_LOW));
        scl_fall_stb = enable && first_low;
        scl_rise_stb = enable && (phase == PH_WAIT) && scl_in;
    end
endmodule

// File: rtl/scl_clk_gen_chk.sv
// Checker: port-level properties of the SCL clock generator, bound to the top.
module scl_clk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_out,
    input logic scl_fall_stb,
    input logic scl_rise_stb
);
    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (scl_out && !scl_fall_stb && !scl_rise_stb)); // R9
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall_stb && scl_rise_stb)); // R8
    AST_FALL_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |-> (!scl_out && $past(scl_out))); // R8
    AST_RISE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_stb |-> (scl_in && scl_out)); // R6
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && scl_out && !scl_in) |=> scl_out); // R6
endmodule

bind scl_clk_gen scl_clk_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .scl_in       (scl_in),
    .scl_out      (scl_out),
    .scl_fall_stb (scl_fall_stb),
    .scl_rise_stb (scl_rise_stb)
);

// File: tb/scl_clk_gen_tb.sv
module scl_clk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        fast_mode = 1'b0;
    logic        duty_alt = 1'b0;
    logic [11:0] ccr = 12'd10;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_out;
    logic        scl_fall_stb;
    logic        scl_rise_stb;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    // A slave may pull the line low. The line is wired-AND with the drive.
    assign scl_in = scl_out & ~hold;

    scl_clk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .duty_alt(duty_alt), .ccr(ccr), .scl_in(scl_in), .scl_out(scl_out),
        .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for the next fall strobe, then measure that low phase and the high phase after it.
    task automatic measure(output int lo, output int hi, output int hr);
        bit seen = 1'b0;
        lo = 0; hi = 0; hr = 0;
        @(negedge clk);
        while (!scl_fall_stb) @(negedge clk);
        while (!scl_out) begin lo++; @(negedge clk); end
        while (!scl_fall_stb) begin
            hi++;
            if (scl_rise_stb) seen = 1'b1;
            if (seen) hr++;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input bit f, input bit d, input int c);
        @(negedge clk);
        fast_mode = f; duty_alt = d; ccr = 12'(c);
    endtask

    task automatic run_ratio(input bit f, input bit d, input int c,
                             input int exp_lo, input int exp_hi, input string req);
        int lo, hi, hr;
        set_cfg(f, d, c);
        measure(lo, hi, hr);
        check(lo == exp_lo, {req, " low"}, lo, exp_lo);
        check(hi == exp_hi, {req, " high"}, hi, exp_hi);
        check(hr == exp_hi, {req, " rise strobe start"}, hr, exp_hi);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(scl_out == 1'b1, "R10 scl_out", int'(scl_out), 1);
        check(!scl_fall_stb && !scl_rise_stb, "R10 strobes",
              int'(scl_fall_stb) + int'(scl_rise_stb), 0);
    endtask

    task automatic test_enable();
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(scl_fall_stb == 1'b1, "R9 first low after enable", int'(scl_fall_stb), 1);
        check(scl_out == 1'b0, "R9 line low after enable", int'(scl_out), 0);
        @(negedge clk);
        check(scl_fall_stb == 1'b0, "R8 fall strobe one cycle", int'(scl_fall_stb), 0);
    endtask

    task automatic test_r1_100k();
        int lo, hi, hr;
        set_cfg(1'b0, 1'b0, 'h28);
        measure(lo, hi, hr);
        check(lo + hi == 80, "R1 period for 0x28", lo + hi, 80);
    endtask

    // R6: hold the line low for 7 cycles after the low phase ends.
    task automatic test_stretch();
        int lo = 0, stalled = 0, hr = 0, rises = 0;
        set_cfg(1'b0, 1'b0, 6);
        @(negedge clk);
        while (!scl_fall_stb) @(negedge clk);
        while (!scl_out) begin lo++; @(negedge clk); end
        hold = 1'b1;
        #1;
        for (int i = 0; i < 7; i++) begin
            if (scl_rise_stb) rises++;
            if (scl_out) stalled++;
            @(negedge clk);
        end
        hold = 1'b0;
        #1;
        check(rises == 0, "R6 no rise strobe while held", rises, 0);
        check(stalled == 7, "R6 drive released while held", stalled, 7);
        check(scl_rise_stb == 1'b1, "R6 rise strobe on release", int'(scl_rise_stb), 1);
        while (!scl_fall_stb) begin hr++; @(negedge clk); end
        check(hr == 6, "R6 full high after release", hr, 6);
    endtask

    // R7: change the control value in the middle of a high phase.
    task automatic test_change();
        int hi = 0, lo = 0, lo2, hi2, hr2;
        set_cfg(1'b0, 1'b0, 6);
        @(negedge clk);
        while (!scl_fall_stb) @(negedge clk);
        while (!scl_rise_stb) @(negedge clk);
        @(negedge clk);
        hi = 1;
        ccr = 12'd12;
        while (!scl_fall_stb) begin hi++; @(negedge clk); end
        check(hi == 6, "R7 current high keeps old length", hi, 6);
        while (!scl_out) begin lo++; @(negedge clk); end
        check(lo == 12, "R7 next low uses new value", lo, 12);
        measure(lo2, hi2, hr2);
        check(hi2 == 12, "R7 later high uses new value", hi2, 12);
    endtask

    task automatic test_disable();
        int bad = 0;
        @(negedge clk);
        enable = 1'b0;
        #1;
        for (int i = 0; i < 20; i++) begin
            if (!scl_out || scl_fall_stb || scl_rise_stb) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9 released and quiet while disabled", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_enable();
        run_ratio(1'b0, 1'b0, 10, 10, 10, "R1 standard");
        test_r1_100k();
        run_ratio(1'b1, 1'b0, 5, 10, 5, "R2 fast 1:2");
        run_ratio(1'b1, 1'b1, 3, 48, 27, "R3 fast 16:9");
        run_ratio(1'b0, 1'b0, 2, 4, 4, "R4 standard clamp");
        run_ratio(1'b1, 1'b0, 0, 8, 4, "R4 fast clamp");
        run_ratio(1'b1, 1'b1, 0, 16, 9, "R5 alt duty clamp");
        run_ratio(1'b1, 1'b1, 1, 16, 9, "R5 alt duty value 1");
        test_stretch();
        test_change();
        test_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule